// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside an 8-bit processor core and decides which of seven input devices may interrupt it. The devices have a fixed ranking, device 0 the most urgent and device 6 the least, and each device index is also its 3-bit urgency level. The block holds a latched pending bit per device, a processor-side mask register and a per-device control register. It also holds a status register with a global interrupt enable and the level of the code that is running now. The normal program runs at level 7.

The block raises a request to the core only when the global enable is set and the most urgent eligible device is strictly more urgent than the running level. When the core acknowledges, the block saves the running level on an internal stack, adopts the winner's level, drops the global enable and retires the winner's pending bit. A return pops the saved level and re-arms the global enable. Handlers can therefore nest, with each one pre-empted only by strictly more urgent devices. Eligible requests that cannot win against the running level while the global enable is set are discarded.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the pending and mask registers read 0. The status register reads 0x38, which is level 7 with the global enable clear. `irq_req` is 0 and `irq_grant` is 0.
- R2: A high `dev_irq[i]` sets pending bit i on the next clock edge. Address 0 reads pending bits 6:0 in bits 6:0, and writing 1 to bit i at address 0 clears pending bit i.
- R3: Address 8+i is device i's control register. Bit 7 is a writable enable, and bits 2:0 read the fixed level i, which writes do not change. A device is eligible only if its pending bit is set, its bit in the mask register (address 1) is 1, and its control enable is 1.
- R4: Among eligible devices, the lowest index wins. `irq_vec` gives its index, and while `irq_req` is high `irq_grant` is the one-hot of that index.
- R5: `irq_req` is 1 only when the global enable is 1 and the winner's level is numerically below the running level. Otherwise `irq_grant` is 0.
- R6: While the global enable is 1, an eligible device whose level is equal to or above the running level has its pending bit cleared on the next edge. While the enable is 0, pending bits are kept.
- R7: When `irq_ack` is high and `irq_req` is high, on the next edge the running level becomes the winner's index, the global enable clears and the winner's pending bit clears.
- R8: An `irq_ret` with a non-empty stack restores the most recently saved level and sets the global enable. Nested acknowledges unwind in last-in, first-out order.
- R9: `irq_ret` with an empty stack has no effect. `irq_ack` while `irq_req` is 0 has no effect.
- R10: Address 2 is the status register, with bit 0 the global enable and bits 5:3 the running level (bit 3 the LSB). Other bits read 0. A write takes effect on the next edge, so a newly allowed request is raised in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 7 | Per-device interrupt signal, sets pending |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data at `addr` (combinational) |
| irq_ack | input | 1 | Core accepts the current request |
| irq_ret | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_grant | output | 7 | One-hot winning device while requesting |
| irq_vec | output | 3 | Index of the winning eligible device |

## Verification
The in-RTL properties check, on every cycle, the following. The grant is one-hot and names the lowest eligible device. An accepted acknowledge lowers the running level to the winner and masks further requests. A return re-arms the enable. The saved-level stack never overflows or underflows, and a raised device signal always lands in its pending bit. Some behaviours show only in the bench's scenarios: the strict-inequality comparison at equal levels, discarding of non-winning requests, the last-in, first-out unwinding across two nested handlers, and the register read layouts with their ignored bits.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam int unsigned ADR_PEND      = 0;
   localparam int unsigned ADR_MASK      = 1;
   localparam int unsigned ADR_STAT      = 2;
   localparam int unsigned ADR_DCTL_BASE = 8;
   localparam int unsigned STAT_GIE_BIT  = 0;
   localparam int unsigned STAT_LVL_LSB  = 3;
   localparam int unsigned DCTL_IE_BIT   = 7;
endpackage

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
   parameter int N     = 7,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     elig,
   output logic             any,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx
);
   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign blocked[i+1] = blocked[i] | elig[i];
      assign grant[i]     = elig[i] & ~blocked[i];
   end

   assign any = blocked[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
   parameter int DEPTH = 7,
   parameter int W     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = $clog2(DEPTH + 1);
   localparam int SLOTS = 1 << PTR_W;

   logic [W-1:0]     mem [SLOTS];
   logic [PTR_W-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == PTR_W'(DEPTH));
   assign top   = empty ? '0 : mem[cnt - PTR_W'(1)];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !full) begin
         cnt <= cnt + PTR_W'(1);
      end else if (pop && !empty) begin
         cnt <= cnt - PTR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[cnt] <= din;
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);     // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);    // R9
   AST_NO_PUSH_POP:  assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));    // R8
endmodule

// File: rtl/nic_pend_bank.sv
module nic_pend_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr) | set;
   end

   AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((pend & $past(set)) == $past(set)));                        // R2
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~set)) |=> ((pend & $past(clr & ~set)) == '0));                 // R6
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int N_DEV  = 7,
   parameter int LVL_W  = 3,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DEV-1:0]  dev_irq,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic              irq_req,
   output logic [N_DEV-1:0]  irq_grant,
   output logic [LVL_W-1:0]  irq_vec
);
   localparam int STK_DEPTH = N_DEV;

   if (N_DEV >= (1 << LVL_W)) begin : g_bad_levels
      $error("N_DEV must leave one level code free for the main program");
   end
   if (N_DEV > DATA_W || DCTL_IE_BIT >= DATA_W || STAT_LVL_LSB + LVL_W > DATA_W) begin : g_bad_data
      $error("DATA_W too narrow for the register layout");
   end
   if (DCTL_IE_BIT < LVL_W) begin : g_bad_dctl
      $error("device enable bit overlaps the level field");
   end
   if (ADR_DCTL_BASE + N_DEV > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the device control registers");
   end

   logic [N_DEV-1:0] pend, mask_q, dev_ie_q, elig, grant_raw, discard, clr, wr_dctl;
   logic [LVL_W-1:0] win_idx, cur_lvl, stk_top;
   logic             any_elig, gie, win_urgent, ack_take, ret_take;
   logic             stk_empty, stk_full, wr_pend, wr_mask, wr_stat;

   assign wr_pend = wr_en && (addr == ADDR_W'(ADR_PEND));
   assign wr_mask = wr_en && (addr == ADDR_W'(ADR_MASK));
   assign wr_stat = wr_en && (addr == ADDR_W'(ADR_STAT));

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= wr_data[N_DEV-1:0];
   end

   for (genvar i = 0; i < N_DEV; i++) begin : g_dev
      assign wr_dctl[i] = wr_en && (addr == ADDR_W'(ADR_DCTL_BASE + i));
      always_ff @(posedge clk) begin
         if (!rst_n)          dev_ie_q[i] <= 1'b0;
         else if (wr_dctl[i]) dev_ie_q[i] <= wr_data[DCTL_IE_BIT];
      end
      assign discard[i] = gie && elig[i] && (LVL_W'(i) >= cur_lvl);
   end

   assign elig = pend & mask_q & dev_ie_q;

   nic_prio_pick #(.N(N_DEV), .IDX_W(LVL_W)) u_pick (
      .elig  (elig),
      .any   (any_elig),
      .grant (grant_raw),
      .idx   (win_idx)
   );

   assign win_urgent = (win_idx < cur_lvl);
   assign irq_req    = gie && any_elig && win_urgent;
   assign irq_grant  = irq_req ? grant_raw : '0;
   assign irq_vec    = win_idx;
   assign ack_take   = irq_req && irq_ack;
   assign ret_take   = irq_ret && !ack_take && !stk_empty;

   assign clr = discard
              | (ack_take ? grant_raw : '0)
              | (wr_pend ? wr_data[N_DEV-1:0] : '0);

   nic_pend_bank #(.N(N_DEV)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (dev_irq),
      .clr   (clr),
      .pend  (pend)
   );

   nic_lvl_stack #(.DEPTH(STK_DEPTH), .W(LVL_W)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ack_take),
      .pop   (ret_take),
      .din   (cur_lvl),
      .top   (stk_top),
      .empty (stk_empty),
      .full  (stk_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie     <= 1'b0;
         cur_lvl <= '1;
      end else if (ack_take) begin
         gie     <= 1'b0;
         cur_lvl <= win_idx;
      end else if (ret_take) begin
         gie     <= 1'b1;
         cur_lvl <= stk_top;
      end else if (wr_stat) begin
         gie     <= wr_data[STAT_GIE_BIT];
         cur_lvl <= wr_data[STAT_LVL_LSB +: LVL_W];
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == ADDR_W'(ADR_PEND)) begin
         rd_data[N_DEV-1:0] = pend;
      end else if (addr == ADDR_W'(ADR_MASK)) begin
         rd_data[N_DEV-1:0] = mask_q;
      end else if (addr == ADDR_W'(ADR_STAT)) begin
         rd_data[STAT_GIE_BIT]              = gie;
         rd_data[STAT_LVL_LSB +: LVL_W]     = cur_lvl;
      end else begin
         for (int i = 0; i < N_DEV; i++) begin
            if (addr == ADDR_W'(ADR_DCTL_BASE + i)) begin
               rd_data[DCTL_IE_BIT] = dev_ie_q[i];
               rd_data[LVL_W-1:0]   = LVL_W'(i);
            end
         end
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_raw));  // R4
   AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((elig & (irq_grant - N_DEV'(1))) == '0));                                    // R4
   AST_ACK_ENTRY:    assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> (!gie && cur_lvl == $past(win_idx)));                                         // R7
   AST_ACK_RETIRES:  assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && ((dev_irq & grant_raw) == '0)) |=> ((pend & $past(grant_raw)) == '0));        // R7
   AST_RET_REARMS:   assert property (@(posedge clk) disable iff (!rst_n) ret_take |=> gie);     // R8
   AST_NO_STK_FULL:  assert property (@(posedge clk) disable iff (!rst_n) ack_take |-> !stk_full); // R8
endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] dev_irq = '0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq_ack = 1'b0;
   logic       irq_ret = 1'b0;
   logic       irq_req;
   logic [6:0] irq_grant;
   logic [2:0] irq_vec;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   nest_irq_ctrl u_nest_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_grant(irq_grant), .irq_vec(irq_vec)
   );

   // {pending[27:21], mask[20:14], dev_enable[13:7], level[6:4], exp_req[3], exp_vec[2:0]}
   localparam logic [27:0] TBL [10] = '{
      {7'b0000101, 7'b1111111, 7'b1111111, 3'd7, 1'b1, 3'd0},  // R4 A beats C
      {7'b0000101, 7'b1111110, 7'b1111111, 3'd7, 1'b1, 3'd2},  // R3 mask hides A
      {7'b0000101, 7'b1111111, 7'b1111110, 3'd7, 1'b1, 3'd2},  // R3 device enable hides A
      {7'b1000000, 7'b1111111, 7'b1111111, 3'd7, 1'b1, 3'd6},  // R5 G over main
      {7'b1000000, 7'b1111111, 7'b1111111, 3'd6, 1'b0, 3'd0},  // R5 equal level
      {7'b0001000, 7'b1111111, 7'b1111111, 3'd3, 1'b0, 3'd0},  // R5 D at level 3
      {7'b0001000, 7'b1111111, 7'b1111111, 3'd4, 1'b1, 3'd3},  // R5 D at level 4
      {7'b1111111, 7'b1111111, 7'b1111111, 3'd1, 1'b1, 3'd0},  // R4 all pending
      {7'b1111110, 7'b1111111, 7'b1111111, 3'd1, 1'b0, 3'd0},  // R5 B at level 1
      {7'b1000000, 7'b0000000, 7'b1111111, 3'd7, 1'b0, 3'd0}   // R3 nothing masked in
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      addr = a;
      #0.5;
      v = rd_data;
   endtask

   task automatic pulse(input logic [6:0] m);
      dev_irq = m;
      tick();
      dev_irq = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick(); tick();
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      @(negedge clk);
      do_reset();

      for (int k = 0; k < 10; k++) begin
         logic [27:0] e;
         e = TBL[k];
         wr(4'd2, 8'h00);
         wr(4'd0, 8'h7F);
         wr(4'd1, {1'b0, e[20:14]});
         for (int d = 0; d < 7; d++) wr(4'(8 + d), {e[7 + d], 7'b0});
         wr(4'd2, {2'b00, e[6:4], 2'b00, 1'b1});
         pulse(e[27:21]);
         chk($sformatf("R5 row %0d irq_req", k), {7'b0, irq_req}, {7'b0, e[3]});
         chk($sformatf("R4 row %0d irq_grant", k), {1'b0, irq_grant},
             e[3] ? (8'h01 << e[2:0]) : 8'h00);
         if (e[3]) chk($sformatf("R4 row %0d irq_vec", k), {5'b0, irq_vec}, {5'b0, e[2:0]});
      end

      // R1 reset state
      do_reset();
      rd(4'd0, v); chk("R1 pending", v, 8'h00);
      rd(4'd1, v); chk("R1 mask", v, 8'h00);
      rd(4'd2, v); chk("R1 status", v, 8'h38);
      chk("R1 irq_req", {7'b0, irq_req}, 8'h00);
      chk("R1 irq_grant", {1'b0, irq_grant}, 8'h00);

      // R3 device control layout
      wr(4'd10, 8'hFF);
      rd(4'd10, v); chk("R3 ctrl C", v, 8'h82);
      for (int d = 0; d < 7; d++) wr(4'(8 + d), 8'h80);
      rd(4'd14, v); chk("R3 ctrl G", v, 8'h86);

      // R2 pending set and write-one-to-clear, enable off
      wr(4'd1, 8'h7F);
      pulse(7'b0010100);
      rd(4'd0, v); chk("R2 pending set", v, 8'h14);
      chk("R5 no req with enable clear", {7'b0, irq_req}, 8'h00);
      wr(4'd0, 8'h04);
      rd(4'd0, v); chk("R2 clear C only", v, 8'h10);
      wr(4'd0, 8'h10);
      rd(4'd0, v); chk("R2 clear E", v, 8'h00);

      // R10 status layout
      wr(4'd2, 8'hFF);
      rd(4'd2, v); chk("R10 status bits", v, 8'h39);

      // R7 entry into handler for C
      pulse(7'b0000100);
      chk("R7 req C", {7'b0, irq_req}, 8'h01);
      chk("R4 vec C", {5'b0, irq_vec}, 8'h02);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      rd(4'd2, v); chk("R7 status after ack", v, 8'h10);
      rd(4'd0, v); chk("R7 pending retired", v, 8'h00);

      // R5 A waits while enable clear
      pulse(7'b0000001);
      chk("R5 A held off", {7'b0, irq_req}, 8'h00);
      wr(4'd2, 8'h11);
      chk("R10 req after enable write", {7'b0, irq_req}, 8'h01);
      chk("R4 vec A", {5'b0, irq_vec}, 8'h00);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      rd(4'd2, v); chk("R7 nested status", v, 8'h00);

      // R8 unwind
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      rd(4'd2, v); chk("R8 first return", v, 8'h11);
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      rd(4'd2, v); chk("R8 second return", v, 8'h39);

      // R9 ignored return and acknowledge
      wr(4'd2, 8'h28);
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      rd(4'd2, v); chk("R9 return on empty stack", v, 8'h28);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      rd(4'd2, v); chk("R9 ack without request", v, 8'h28);

      // R6 discard when not urgent enough
      wr(4'd2, 8'h31);
      pulse(7'b1000000);
      chk("R6 G not raised", {7'b0, irq_req}, 8'h00);
      tick();
      rd(4'd0, v); chk("R6 G discarded", v, 8'h00);
      wr(4'd2, 8'h30);
      pulse(7'b1000000);
      tick();
      rd(4'd0, v); chk("R6 G kept with enable clear", v, 8'h40);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule